// File: doc/BRIEF.md
# Buffered-Duty 8-bit PWM Timer

A single-channel pulse-width generator driven by a selectable prescaler. A 3-bit select picks one of eight system-clock divisors (2, 8, 32, 128, 256, 1024, 2048, 4096). The prescaler emits a one-cycle tick at that rate. Each tick advances an 8-bit period counter that runs from 0 to 249 and then wraps to 0, so one period is 250 ticks long.

The output is active from the start of each period until the counter equals the active duty value. It then stays inactive until the wrap. A polarity input inverts the waveform. While the timer is enabled, duty writes land in a buffer, and the compare value reloads from that buffer only at the wrap, so a period is never cut short or stretched. While the timer is disabled, the counter sits at 0, the output and its valid flag are low so the pin can serve another use, and duty writes take effect at once.

Top module: `pwm_buffered_timer`

## Requirements
- R1: The prescaler tick period is 2, 8, 32, 128, 256, 1024, 2048 or 4096 system clocks for clock-select codes 0 through 7. The first active period after the enable rises holds the counter at 0 for exactly one full divisor. With a duty value of 1, the first high pulse therefore lasts exactly that many clocks.
- R2: When enabled, the counter steps by one on each tick and wraps from 249 (0xF9) to 0. At code 0 the period is 500 clocks.
- R3: In reset and while the enable is 0, the counter is 0. One clock after the enable is sampled low, pwm_o and pwm_oe_o are both 0. pwm_oe_o is 1 one clock after the enable is sampled high.
- R4: While the enable is 0, a duty write loads the active compare value at the next clock edge.
- R5: While enabled, a duty write changes only the buffer. The active compare value reloads at the wrap from 249 to 0. A write in the very cycle of the wrap is the value that loads.
- R6: With polarity 0, pwm_o is 1 in the clock after the counter is below the active duty value, and 0 otherwise. The output is registered and lags the counter by one clock.
- R7: With polarity 1, pwm_o is the inverse of the R6 waveform while enabled.
- R8: A duty value of 0 keeps the output inactive for the whole period. A duty value of 250 or more keeps it active for the whole period.
- R9: A change of the clock select restarts the prescaler. The counter then next advances exactly one new divisor of clocks after the edge that first samples the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| inv_i | input | 1 | Output polarity, 1 inverts |
| clk_sel_i | input | 3 | Prescaler divisor select |
| duty_we_i | input | 1 | Duty write strobe |
| duty_wdata_i | input | 8 | Duty write value |
| pwm_o | output | 1 | Registered PWM output |
| pwm_oe_o | output | 1 | Output-valid flag, high while the pin is driven |

## Verification
A duty write and the period wrap can fall in the same clock. In that case the written value, not the old buffer, must become the compare value for the new period. The bench tracks the expected counter and prescaler state and raises the write strobe exactly in the cycle before the wrap edge. It then judges the result by the number of high clocks in the following period. Randomly timed writes, select changes and enable toggles against a per-cycle expected model widen the same collision to arbitrary phases.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned CNT_LAST = 249;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned PRE_W    = 12;

  // terminal prescaler count for each select code
  function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    int unsigned sh;
    case (sel)
      3'd0:    sh = 1;
      3'd1:    sh = 3;
      3'd2:    sh = 5;
      3'd3:    sh = 7;
      3'd4:    sh = 8;
      3'd5:    sh = 10;
      3'd6:    sh = 11;
      default: sh = 12;
    endcase
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             restart;

  assign restart = (sel_i != sel_q);
  assign tick_o  = run_i && !restart && (cnt_q == div_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (!run_i || restart || tick_o) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CNT_LAST);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_duty_reg.sv
module pwm_duty_reg
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] buf_o
);
  logic [CNT_W-1:0] buf_q, act_q;

  assign act_o = act_q;
  assign buf_o = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) buf_q <= wdata_i;
      if (!run_i && we_i) act_q <= wdata_i;
      else if (wrap_i)    act_q <= we_i ? wdata_i : buf_q; // same-cycle write wins
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             oe_o
);
  logic pwm_q, oe_q, active;

  assign active = (cnt_i < duty_i);
  assign pwm_o  = pwm_q;
  assign oe_o   = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= run_i;
      pwm_q <= run_i ? (active ^ inv_i) : 1'b0;
    end
  end
endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             duty_we_i,
  input  logic [7:0]       duty_wdata_i,
  output logic             pwm_o,
  output logic             pwm_oe_o
);
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt, duty_act, duty_buf;

  pwm_prescaler u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .sel_i(clk_sel_i), .tick_o(tick)
  );

  pwm_period_ctr u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .tick_i(tick),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  pwm_duty_reg u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .wrap_i(wrap),
    .we_i(duty_we_i), .wdata_i(duty_wdata_i), .act_o(duty_act), .buf_o(duty_buf)
  );

  pwm_out_stage u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .inv_i(inv_i),
    .cnt_i(cnt), .duty_i(duty_act), .pwm_o(pwm_o), .oe_o(pwm_oe_o)
  );
endmodule

// File: rtl/pwm_buffered_timer_chk.sv
module pwm_buffered_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       inv_i,
  input logic       duty_we_i,
  input logic [7:0] duty_wdata_i,
  input logic       tick,
  input logic [7:0] cnt,
  input logic [7:0] duty_act,
  input logic       pwm_o,
  input logic       pwm_oe_o
);
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= 8'd249); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick && cnt != 8'd249) |=> cnt == 8'($past(cnt) + 8'd1)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick && cnt == 8'd249) |=> cnt == 8'd0); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R1
  AST_DIS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == 8'd0 && !pwm_o && !pwm_oe_o)); // R3
  AST_DIS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && duty_we_i) |=> duty_act == $past(duty_wdata_i)); // R4
  AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(tick && cnt == 8'd249)) |=> duty_act == $past(duty_act)); // R5
  AST_WRAP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick && cnt == 8'd249 && duty_we_i) |=> duty_act == $past(duty_wdata_i)); // R5
  AST_WAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> pwm_o == (($past(cnt) < $past(duty_act)) ^ $past(inv_i))); // R6
  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_oe_o |-> !pwm_o); // R3
endmodule

bind pwm_buffered_timer pwm_buffered_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .inv_i(inv_i),
  .duty_we_i(duty_we_i), .duty_wdata_i(duty_wdata_i), .tick(tick), .cnt(cnt),
  .duty_act(duty_act), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
);

// File: tb/tb_pwm_buffered_timer.sv
`timescale 1ns/1ps
module tb_pwm_buffered_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, inv = 1'b0, we = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       pwm, oe;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  pwm_buffered_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .inv_i(inv), .clk_sel_i(sel),
    .duty_we_i(we), .duty_wdata_i(wdata), .pwm_o(pwm), .pwm_oe_o(oe)
  );

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd0: return 2;    3'd1: return 8;    3'd2: return 32;   3'd3: return 128;
      3'd4: return 256;  3'd5: return 1024; 3'd6: return 2048; default: return 4096;
    endcase
  endfunction

  // expected-state model built from the requirements
  int         m_pc = 0, m_cnt = 0;
  logic [2:0] m_sel = 3'd0;
  logic [7:0] m_buf = 8'd0, m_act = 8'd0;
  logic       m_out = 1'b0, m_oe = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= 0; m_cnt <= 0; m_sel <= 3'd0; m_buf <= 8'd0; m_act <= 8'd0;
      m_out <= 1'b0; m_oe <= 1'b0;
    end else begin
      automatic bit chg  = (sel != m_sel);                                 // R9
      automatic bit tk   = en && !chg && (m_pc == div_of(sel) - 1);        // R1
      automatic bit wrp  = tk && (m_cnt == 249);                           // R2
      m_sel <= sel;
      m_pc  <= (!en || chg || tk) ? 0 : m_pc + 1;
      m_cnt <= !en ? 0 : wrp ? 0 : tk ? m_cnt + 1 : m_cnt;
      if (we) m_buf <= wdata;
      if (!en && we) m_act <= wdata;                                       // R4
      else if (wrp)  m_act <= we ? wdata : m_buf;                          // R5
      m_oe  <= en;
      m_out <= en ? ((m_cnt < int'(m_act)) ^ inv) : 1'b0;                  // R6 R7
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check("R6 R7 R9 pwm_o vs model", int'(pwm), int'(m_out));
      check("R3 pwm_oe_o vs model", int'(oe), int'(m_oe));
    end
  end

  task automatic write_duty(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += int'(pwm);
    end
  endtask

  task automatic wait_wrap_cycle();
    // stop at the negedge just before the edge that wraps 249 -> 0
    int guard = 0;
    while (!(en && sel == m_sel && m_pc == div_of(sel) - 1 && m_cnt == 249) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic wait_cnt(input int v);
    int guard = 0;
    while (!(m_cnt == v && m_pc == 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    int h, w;
    repeat (3) @(negedge clk);
    check("R3 reset pwm_o", int'(pwm), 0);
    check("R3 reset pwm_oe_o", int'(oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;

    // R1: first-period pulse width equals divisor, for every select code
    for (int s = 0; s < 8; s++) begin
      en = 1'b0;
      sel = 3'(s);
      write_duty(8'd1);             // R4 immediate load while disabled
      @(negedge clk);
      en = 1'b1;
      w = 0;
      @(negedge clk);
      while (pwm && w < 5000) begin w++; @(negedge clk); end
      check($sformatf("R1 R4 high width sel=%0d", s), w, div_of(3'(s)));
      en = 1'b0;
      @(negedge clk);
      check("R3 disabled pwm_oe_o", int'(oe), 0);
      check("R3 disabled pwm_o", int'(pwm), 0);
    end

    // R2: period length at code 0
    sel = 3'd0;
    write_duty(8'd125);
    en = 1'b1;
    @(negedge clk);
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    w = 0;
    while (pwm) begin w++; @(negedge clk); end
    while (!pwm) begin w++; @(negedge clk); end
    check("R2 period clocks", w, 500);

    // R8: duty 0 and duty >= 250 (write at wrap to load)
    wait_wrap_cycle(); write_duty(8'd0);
    count_high(500, h);
    check("R8 duty 0 high clocks", h, 0);
    wait_wrap_cycle(); write_duty(8'd250);
    @(negedge clk);
    count_high(500, h);
    check("R8 duty 250 high clocks", h, 500);
    wait_wrap_cycle(); write_duty(8'd255);
    @(negedge clk);
    count_high(500, h);
    check("R8 duty 255 high clocks", h, 500);

    // R7: inverted waveform
    wait_wrap_cycle(); write_duty(8'd100);
    inv = 1'b1;
    count_high(500, h);
    check("R7 inverted high clocks", h, 300);
    inv = 1'b0;

    // R5: mid-period write stays buffered
    wait_wrap_cycle(); write_duty(8'd50);
    wait_cnt(100);
    write_duty(8'd200);
    count_high(250, h);
    check("R5 buffered write no effect mid period", h, 0);
    // R5: write colliding with the wrap loads the written value
    wait_wrap_cycle();
    write_duty(8'd30);
    count_high(500, h);
    check("R5 write at wrap high clocks", h, 60);

    // R9 and random mix checked per cycle against model
    void'($urandom(32'd20250611));
    for (int seg = 0; seg < 60; seg++) begin
      automatic int len = 200 + int'($urandom % 1500);
      if ($urandom % 4 == 0) sel = 3'($urandom % 3);          // R9 restart
      if ($urandom % 5 == 0) en = ~en;
      if ($urandom % 6 == 0) inv = ~inv;
      for (int c = 0; c < len; c++) begin
        if ($urandom % 97 == 0) begin
          we = 1'b1;
          wdata = ($urandom % 8 == 0) ? 8'(250 + $urandom % 6) : 8'($urandom % 250);
        end else begin
          we = 1'b0;
        end
        @(negedge clk);
      end
      we = 1'b0;
    end
    en = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 final disabled pwm_oe_o", int'(oe), 0);

    model_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule